// File: doc/BRIEF.md
# Audio Transfer Control Register

This block holds the transfer configuration for the two data directions of an audio converter interface, playback and capture. For each direction a host write chooses whether it is enabled and whether its data moves by DMA or by programmed I/O (PIO). One more bit folds both DMA request streams onto the playback request line, so that a system with only one DMA channel can still run the converter. A two-bit field chooses the type of calibration to run.

Only the two enable bits may be written at any time. The other configuration bits take a write only while one of the two mode-change flags (`mce`, `pmce`) is high. When `mce` falls, a calibration sequencer (states `CAL_IDLE` and `CAL_RUN`) counts the selected number of sample-period ticks. It moves from `CAL_IDLE` to `CAL_RUN` on the falling edge of `mce` when the selected length is not zero, and from `CAL_RUN` back to `CAL_IDLE` on the tick that uses up the count. While it is busy, all DMA requests and PIO-ready flags are held low.

Each direction has a request tracker with the states `REQ_IDLE` and `REQ_PEND`. It moves from `REQ_IDLE` to `REQ_PEND` on a data-needed strobe while its DMA path is active. It moves from `REQ_PEND` back to `REQ_IDLE` on an acknowledge with no new strobe in the same cycle, or at once when its DMA path stops being active.

Top module: `audio_xfer_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x08, and every request, PIO-ready and busy output is 0.
- R2: A write sets bit 0 (playback enable) and bit 1 (capture enable) at any time. The new value appears on `rd_data` in the cycle after the write.
- R3: A write updates bit 7 (capture PIO), bit 6 (playback PIO), bits 4:3 (calibration select) and bit 2 (single channel) only while `mce` or `pmce` is high, and leaves them unchanged otherwise. Bit 5 always reads 0.
- R4: When `mce` falls, `cal_busy` rises in the cycle after the falling edge is sampled. It stays high for N `sample_tick` pulses, where N is 136 for select 1, 40 for select 2 and 168 for select 3.
- R5: With select 0, the first fall of `mce` after reset gives a 40-tick calibration. Every later fall gives no calibration.
- R6: While `cal_busy` is high, `pb_drq`, `cap_drq`, `pb_pio_rdy` and `cap_pio_rdy` are all 0.
- R7: The playback DMA path is active when playback is enabled and playback PIO is 0. In that state `pb_need` raises `pb_drq` in the next cycle and `pb_ack` lowers it in the next cycle. Clearing the enable or setting PIO drops the request in the cycle the register changes, and leaves no pending request behind.
- R8: Capture follows the rule of R7, using `cap_need`, `cap_ack` and `cap_drq`.
- R9: `pb_pio_rdy` equals playback enable AND playback PIO, and `cap_pio_rdy` equals capture enable AND capture PIO, outside calibration.
- R10: With single channel set, `cap_drq` is 0. Capture requests appear on `pb_drq` and are acknowledged by `pb_ack`. While playback is enabled, capture DMA is suppressed.
- R11: A rise and fall of `pmce` alone never starts a calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register contents |
| mce | input | 1 | Mode-change flag; its fall starts calibration |
| pmce | input | 1 | Alternate mode-change flag; unlocks writes only |
| sample_tick | input | 1 | One pulse per sample period |
| pb_need | input | 1 | Playback data-needed strobe |
| cap_need | input | 1 | Capture data-needed strobe |
| pb_ack | input | 1 | Playback DMA acknowledge |
| cap_ack | input | 1 | Capture DMA acknowledge |
| pb_drq | output | 1 | Playback DMA request |
| cap_drq | output | 1 | Capture DMA request |
| pb_pio_rdy | output | 1 | Playback PIO path ready |
| cap_pio_rdy | output | 1 | Capture PIO path ready |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The assertions check on every cycle that:
- locked bits hold through writes made outside mode change;
- calibration busy begins only after a sampled `mce` fall and ends only on a tick;
- no request or PIO-ready output is high during calibration;
- the capture request line stays quiet in single-channel mode;
- a request rises only after a data-needed strobe and clears after an acknowledge.

The exact calibration lengths for each select value, the consumption of the first-release calibration, the playback priority in single-channel mode, and the reset readback can only be shown by the bench's scenarios. It counts busy cycles against the requirements and compares register readback through a scoreboard.

// File: rtl/xfer_ctrl_pkg.sv
package xfer_ctrl_pkg;

    typedef struct packed {
        logic       cap_pio;
        logic       pb_pio;
        logic       rsvd;
        logic [1:0] cal_sel;
        logic       one_chan;
        logic       cap_en;
        logic       pb_en;
    } xfer_cfg_t;

    typedef enum logic {
        CAL_IDLE,
        CAL_RUN
    } cal_state_e;

    typedef enum logic {
        REQ_IDLE,
        REQ_PEND
    } req_state_e;

    localparam logic [7:0] CFG_RESET = 8'h08;
    localparam int         NUM_DIR   = 2;
    localparam int         DIR_PB    = 0;
    localparam int         DIR_CAP   = 1;

endpackage

// File: rtl/xfer_cfg_reg.sv
module xfer_cfg_reg
    import xfer_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       mode_chg,
    output xfer_cfg_t  cfg
);

    xfer_cfg_t wr_view;
    assign wr_view = xfer_cfg_t'(wr_data);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= xfer_cfg_t'(CFG_RESET);
        end else if (wr_en) begin
            cfg.pb_en  <= wr_view.pb_en;
            cfg.cap_en <= wr_view.cap_en;
            if (mode_chg) begin
                cfg.one_chan <= wr_view.one_chan;
                cfg.cal_sel  <= wr_view.cal_sel;
                cfg.pb_pio   <= wr_view.pb_pio;
                cfg.cap_pio  <= wr_view.cap_pio;
            end
        end
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_chg) |=> ($stable(cfg.cal_sel) && $stable(cfg.one_chan)
                                  && $stable(cfg.pb_pio) && $stable(cfg.cap_pio)));

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !cfg.rsvd);

endmodule

// File: rtl/xfer_cal_seq.sv
module xfer_cal_seq
    import xfer_ctrl_pkg::*;
#(
    parameter int CONV_LEN  = 136,
    parameter int DAC_LEN   = 40,
    parameter int FULL_LEN  = 168,
    parameter int FIRST_LEN = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mce,
    input  logic       tick,
    input  logic [1:0] cal_sel,
    output logic       busy
);

    localparam int MAX_AB  = (CONV_LEN > DAC_LEN) ? CONV_LEN : DAC_LEN;
    localparam int MAX_CD  = (FULL_LEN > FIRST_LEN) ? FULL_LEN : FIRST_LEN;
    localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    cal_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   len;
    logic               mce_q;
    logic               first_q;
    logic               mce_fall;

    assign mce_fall = mce_q & ~mce;

    always_comb begin
        unique case (cal_sel)
            2'd0: len = first_q ? CNT_W'(FIRST_LEN) : '0;
            2'd1: len = CNT_W'(CONV_LEN);
            2'd2: len = CNT_W'(DAC_LEN);
            2'd3: len = CNT_W'(FULL_LEN);
            default: len = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE: if (mce_fall && (len != '0)) state_d = CAL_RUN;
            CAL_RUN:  if (tick && (cnt_q == CNT_W'(1))) state_d = CAL_IDLE;
            default:  state_d = CAL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            mce_q   <= 1'b0;
            first_q <= 1'b1;
        end else begin
            mce_q <= mce;
            if (mce_fall) first_q <= 1'b0;
            if (state_q == CAL_IDLE && mce_fall) cnt_q <= len;
            else if (state_q == CAL_RUN && tick) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CAL_RUN: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(mce_q) && !$past(mce)));

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    // R5
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

endmodule

// File: rtl/xfer_dma_chan.sv
module xfer_dma_chan
    import xfer_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic need,
    input  logic ack,
    output logic req
);

    req_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE: if (need) state_d = REQ_PEND;
                REQ_PEND: if (ack && !need) state_d = REQ_IDLE;
                default:  state_d = REQ_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            REQ_PEND: req = active;
            default:  req = 1'b0;
        endcase
    end

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !need) |=> !req);

    // R7
    raise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(need));

endmodule

// File: rtl/audio_xfer_ctrl.sv
module audio_xfer_ctrl
    import xfer_ctrl_pkg::*;
#(
    parameter int CONV_LEN  = 136,
    parameter int DAC_LEN   = 40,
    parameter int FULL_LEN  = 168,
    parameter int FIRST_LEN = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       mce,
    input  logic       pmce,
    input  logic       sample_tick,
    input  logic       pb_need,
    input  logic       cap_need,
    input  logic       pb_ack,
    input  logic       cap_ack,
    output logic       pb_drq,
    output logic       cap_drq,
    output logic       pb_pio_rdy,
    output logic       cap_pio_rdy,
    output logic       cal_busy
);

    xfer_cfg_t          cfg;
    logic [NUM_DIR-1:0] dir_en, dir_pio, dir_need, dir_ack, dir_active, dir_req;

    xfer_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mode_chg (mce | pmce),
        .cfg      (cfg)
    );

    xfer_cal_seq #(
        .CONV_LEN  (CONV_LEN),
        .DAC_LEN   (DAC_LEN),
        .FULL_LEN  (FULL_LEN),
        .FIRST_LEN (FIRST_LEN)
    ) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .mce     (mce),
        .tick    (sample_tick),
        .cal_sel (cfg.cal_sel),
        .busy    (cal_busy)
    );

    assign dir_en   = {cfg.cap_en, cfg.pb_en};
    assign dir_pio  = {cfg.cap_pio, cfg.pb_pio};
    assign dir_need = {cap_need, pb_need};
    assign dir_ack  = {(cfg.one_chan ? pb_ack : cap_ack), pb_ack};

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        logic blocked;
        if (d == DIR_CAP) begin : g_cap_gate
            assign blocked = cfg.one_chan & cfg.pb_en;
        end else begin : g_pb_gate
            assign blocked = 1'b0;
        end
        assign dir_active[d] = dir_en[d] & ~dir_pio[d] & ~cal_busy & ~blocked;

        xfer_dma_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (dir_active[d]),
            .need   (dir_need[d]),
            .ack    (dir_ack[d]),
            .req    (dir_req[d])
        );
    end

    assign pb_drq      = dir_req[DIR_PB] | (cfg.one_chan & dir_req[DIR_CAP]);
    assign cap_drq     = ~cfg.one_chan & dir_req[DIR_CAP];
    assign pb_pio_rdy  = cfg.pb_en & cfg.pb_pio & ~cal_busy;
    assign cap_pio_rdy = cfg.cap_en & cfg.cap_pio & ~cal_busy;
    assign rd_data     = {cfg.cap_pio, cfg.pb_pio, 1'b0, cfg.cal_sel,
                          cfg.one_chan, cfg.cap_en, cfg.pb_en};

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> !(pb_drq || cap_drq || pb_pio_rdy || cap_pio_rdy));

    // R10
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |-> !cap_drq);

    // R9
    pio_dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_pio_rdy && pb_drq));

endmodule

// File: tb/test_audio_xfer_ctrl.sv
module test_audio_xfer_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       mce = 1'b0, pmce = 1'b0, sample_tick = 1'b1;
    logic       pb_need = 1'b0, cap_need = 1'b0, pb_ack = 1'b0, cap_ack = 1'b0;
    logic       pb_drq, cap_drq, pb_pio_rdy, cap_pio_rdy, cal_busy;

    int checks = 0;
    int errors = 0;
    logic [7:0] model_cfg;

    typedef struct {
        string      tag;
        logic [7:0] exp;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    audio_xfer_ctrl i_audio_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mce(mce), .pmce(pmce), .sample_tick(sample_tick),
        .pb_need(pb_need), .cap_need(cap_need), .pb_ack(pb_ack), .cap_ack(cap_ack),
        .pb_drq(pb_drq), .cap_drq(cap_drq), .pb_pio_rdy(pb_pio_rdy),
        .cap_pio_rdy(cap_pio_rdy), .cal_busy(cal_busy)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares readback one cycle after each write
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, {24'h0, rd_data}, {24'h0, it.exp});
        end
    end

    task automatic write_cfg(string tag, logic [7:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        if (mce || pmce) model_cfg = v & 8'hDF;
        else             model_cfg = {model_cfg[7:2], v[1:0]};
        @(posedge clk);
        #1;
        sb_q.push_back('{tag, model_cfg});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_need(bit cap);
        if (cap) cap_need = 1'b1; else pb_need = 1'b1;
        @(negedge clk);
        cap_need = 1'b0;
        pb_need  = 1'b0;
    endtask

    task automatic pulse_ack(bit cap);
        if (cap) cap_ack = 1'b1; else pb_ack = 1'b1;
        @(negedge clk);
        cap_ack = 1'b0;
        pb_ack  = 1'b0;
    endtask

    // releases mce after an optional locked-bit write; counts busy cycles
    task automatic run_cal(string tag, logic [7:0] v, bit do_wr, int exp_len,
                           output bit drq_seen);
        int n;
        n = 0;
        drq_seen = 1'b0;
        mce = 1'b1;
        cyc(1);
        if (do_wr) write_cfg(tag, v);
        cyc(1);
        mce = 1'b0;
        for (int i = 0; i < 220; i++) begin
            @(negedge clk);
            if (cal_busy) begin
                n++;
                if (pb_drq || cap_drq || pb_pio_rdy || cap_pio_rdy) drq_seen = 1'b1;
            end
        end
        chk(tag, n, exp_len);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit seen;
        model_cfg = 8'h08;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 rd_data", {24'h0, rd_data}, 32'h08);
        chk("R1 outputs", {27'h0, pb_drq, cap_drq, pb_pio_rdy, cap_pio_rdy, cal_busy}, 0);

        // R2 / R3 locked write
        write_cfg("R3 locked write", 8'hFF);
        cyc(1);
        chk("R2 enables set", {30'h0, rd_data[1:0]}, 3);
        write_cfg("R2 enables clear", 8'h00);

        // R3 via pmce, reserved bit reads 0
        pmce = 1'b1;
        write_cfg("R3 pmce write", 8'h20);
        pmce = 1'b0;
        cyc(4);
        chk("R11 pmce no calibration", {31'h0, cal_busy}, 0);

        // R5 first release with select 0
        run_cal("R5 first release", 8'h00, 1'b0, 40, seen);
        run_cal("R5 later release", 8'h00, 1'b0, 0, seen);

        // R4 lengths
        run_cal("R4 converter cal", 8'h08, 1'b1, 136, seen);
        run_cal("R4 dac cal", 8'h10, 1'b1, 40, seen);
        pb_need = 1'b1;
        run_cal("R4 full cal", 8'h19, 1'b1, 168, seen);
        chk("R6 no request during busy", {31'h0, seen}, 0);
        chk("R7 request after busy", {31'h0, pb_drq}, 1);
        pb_need = 1'b0;

        // R7 ack, raise, disable
        pulse_ack(1'b0);
        chk("R7 ack clears", {31'h0, pb_drq}, 0);
        pulse_need(1'b0);
        chk("R7 need raises", {31'h0, pb_drq}, 1);
        write_cfg("R7 disable write", 8'h18);
        chk("R7 disable drops", {31'h0, pb_drq}, 0);
        cyc(1);
        write_cfg("R7 re-enable write", 8'h19);
        chk("R7 no stale request", {31'h0, pb_drq}, 0);

        // R8 / R9 playback PIO, capture DMA
        pmce = 1'b1;
        write_cfg("R9 pio write", 8'h5B);
        pmce = 1'b0;
        chk("R9 pb pio ready", {30'h0, pb_pio_rdy, cap_pio_rdy}, 2);
        pulse_need(1'b0);
        chk("R7 pio blocks dma", {31'h0, pb_drq}, 0);
        pulse_need(1'b1);
        chk("R8 capture raises", {31'h0, cap_drq}, 1);
        pulse_ack(1'b1);
        chk("R8 capture ack clears", {31'h0, cap_drq}, 0);

        pmce = 1'b1;
        write_cfg("R9 both pio", 8'hC3);
        pmce = 1'b0;
        chk("R9 both ready", {30'h0, pb_pio_rdy, cap_pio_rdy}, 3);
        write_cfg("R9 capture off", 8'h01);
        chk("R9 capture cleared", {30'h0, pb_pio_rdy, cap_pio_rdy}, 2);

        // R10 single channel
        pmce = 1'b1;
        write_cfg("R10 single write", 8'h06);
        pmce = 1'b0;
        pulse_need(1'b1);
        chk("R10 capture on pb line", {30'h0, pb_drq, cap_drq}, 2);
        pulse_ack(1'b0);
        chk("R10 pb_ack clears capture", {31'h0, pb_drq}, 0);
        write_cfg("R10 add playback", 8'h07);
        pulse_need(1'b1);
        chk("R10 capture suppressed", {30'h0, pb_drq, cap_drq}, 0);
        pulse_need(1'b0);
        chk("R10 playback wins", {30'h0, pb_drq, cap_drq}, 2);

        cyc(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule